// File: doc/BRIEF.md
# Predicated Instruction Group Executor

This block is an execution stage for explicitly parallel instruction groups. Each operation carries a guard that names one predicate register. The operation's result is written only when that predicate is true. A compare operation sets two predicate registers at once: one receives the test result and the other its complement. With this, conditional code becomes a set of guarded writes and needs no branches.

Operations arrive one at a time on a valid/ready input. A stop flag on an operation marks it as the last one of its group. Within a group, operations have no order between them. Every source operand and every guard is read from the state that existed before the group started. Every write is held in a pending buffer until the group closes. When the operation that carries the stop flag is accepted, the block spends one cycle committing the pending writes. It holds ready low during that cycle, so the whole group is visible before any operation of the next group executes. One combinational read port on the data registers and one on the predicates expose the committed state.

Top module: `pgx_group_exec`

## Requirements
- R1: A compare (op code 3) compares source A with source B as unsigned numbers. It writes (A > B) to the predicate named by `in_pt` and the inverse of that result to the predicate named by `in_pf`.
- R2: An operation whose guard predicate reads 0 changes no data register and no predicate register.
- R3: Source operands and guards inside a group read the values from before the group. No write of a group can be seen at the read ports until the group has committed.
- R4: After an operation with `in_stop` = 1 is accepted, `in_ready` is 0 for exactly one cycle. At the end of that cycle all pending writes of the group appear in the registers.
- R5: Predicate 0 always reads 1, and writes to it are discarded. An operation guarded by predicate 0 therefore always takes effect.
- R6: Two writes in one group can land on the same register, data or predicate, with both of them enabled. In that case `err_o` is 1 during the commit cycle of that group and the value from the later-issued write is kept. If a compare names the same predicate in both `in_pt` and `in_pf`, that also counts as two writes, and the complement value is kept.
- R7: Op codes: 0 loads `in_imm` into the destination, 1 copies source A, 2 writes A + B modulo 2^DW, 3 is the compare of R1.
- R8: After reset, every data register reads 0, every predicate except predicate 0 reads 0, `err_o` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation can be accepted (0 during a commit cycle) |
| in_op | input | 2 | Operation code |
| in_guard | input | PW | Guard predicate index |
| in_dst | input | RW | Destination data register |
| in_pt | input | PW | Predicate that receives the compare result |
| in_pf | input | PW | Predicate that receives the inverse result |
| in_ra | input | RW | Source A register |
| in_rb | input | RW | Source B register |
| in_imm | input | DW | Immediate for load |
| in_stop | input | 1 | Last operation of its group |
| err_o | output | 1 | Duplicate-destination error, shown during the commit cycle |
| obs_ridx | input | RW | Data register read index |
| obs_rdat | output | DW | Committed value of that data register |
| obs_pidx | input | PW | Predicate read index |
| obs_pdat | output | 1 | Committed value of that predicate |

## Verification
The hardest case to reach is a group where the same predicates are both written and used as guards. A stale guard read and a read of the pending value then give different results. The stimulus sets the predicate pair with a compare, and in a later group it flips the pair while also issuing a write guarded by the old value. A following group guards both a write and a compare with a false predicate. The other hard case is two enabled writes to one register within a group, for data and for predicates. Two groups issue such writes back to back and check both `err_o` during the commit cycle and the winning value.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  typedef enum logic [1:0] {
    OP_LDI   = 2'd0,
    OP_COPY  = 2'd1,
    OP_SUM   = 2'd2,
    OP_CMPGT = 2'd3
  } pgx_op_e;

  typedef enum logic {
    ST_ACCEPT = 1'b0,
    ST_COMMIT = 1'b1
  } pgx_state_e;
endpackage

// File: rtl/pgx_alu.sv
module pgx_alu #(
  parameter int DW = 16
) (
  input  logic [1:0]    op,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  input  logic [DW-1:0] imm,
  output logic [DW-1:0] result,
  output logic          a_gt_b
);
  import pgx_pkg::*;

  always_comb begin
    a_gt_b = (src_a > src_b);
    unique case (pgx_op_e'(op))
      OP_LDI:  result = imm;
      OP_COPY: result = src_a;
      OP_SUM:  result = src_a + src_b;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/pgx_regfile.sv
module pgx_regfile #(
  parameter int NENT  = 8,
  parameter int W     = 16,
  parameter int NWP   = 1,
  parameter int NRP   = 2,
  parameter bit HARD0 = 1'b0,
  localparam int IW   = $clog2(NENT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NWP-1:0]         wr_en,
  input  logic [NWP-1:0][IW-1:0] wr_idx,
  input  logic [NWP-1:0][W-1:0]  wr_dat,
  input  logic                   commit,
  input  logic [NRP-1:0][IW-1:0] rd_idx,
  output logic [NRP-1:0][W-1:0]  rd_dat,
  output logic [NENT-1:0][W-1:0] arch_o,
  output logic                   dup_o
);
  logic [NENT-1:0][W-1:0] arch_q, arch_d;
  logic [NENT-1:0][W-1:0] pd_q, pd_d;
  logic [NENT-1:0]        pv_q, pv_d;

  // Next-state: writes go to the pending buffer; commit folds it into arch.
  always_comb begin
    arch_d = arch_q;
    pd_d   = pd_q;
    pv_d   = pv_q;
    dup_o  = 1'b0;
    if (commit) begin
      for (int e = 0; e < NENT; e++) begin
        if (pv_q[e]) arch_d[e] = pd_q[e];
      end
      pv_d = '0;
    end else begin
      for (int p = 0; p < NWP; p++) begin
        if (wr_en[p] && !(HARD0 && wr_idx[p] == '0)) begin
          if (pv_d[wr_idx[p]]) dup_o = 1'b1;
          pv_d[wr_idx[p]] = 1'b1;
          pd_d[wr_idx[p]] = wr_dat[p];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arch_q <= '0;
      pd_q   <= '0;
      pv_q   <= '0;
    end else begin
      arch_q <= arch_d;
      pd_q   <= pd_d;
      pv_q   <= pv_d;
    end
  end

  generate
    for (genvar r = 0; r < NRP; r++) begin : g_rd
      if (HARD0) begin : g_hard
        assign rd_dat[r] = (rd_idx[r] == '0) ? {W{1'b1}} : arch_q[rd_idx[r]];
      end else begin : g_plain
        assign rd_dat[r] = arch_q[rd_idx[r]];
      end
    end
  endgenerate

  assign arch_o = arch_q;
endmodule

// File: rtl/pgx_ctrl.sv
module pgx_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_stop,
  input  logic dup_any,
  output logic in_ready,
  output logic fire,
  output logic commit,
  output logic err_o
);
  import pgx_pkg::*;

  pgx_state_e state_q, state_d;
  logic       dup_seen_q, dup_seen_d;

  assign in_ready = (state_q == ST_ACCEPT);
  assign fire     = in_valid && in_ready;
  assign commit   = (state_q == ST_COMMIT);
  assign err_o    = commit && dup_seen_q;

  always_comb begin
    state_d    = state_q;
    dup_seen_d = dup_seen_q;
    if (commit) begin
      state_d    = ST_ACCEPT;
      dup_seen_d = 1'b0;
    end else if (fire) begin
      if (dup_any) dup_seen_d = 1'b1;
      if (in_stop) state_d = ST_COMMIT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_ACCEPT;
      dup_seen_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      dup_seen_q <= dup_seen_d;
    end
  end
endmodule

// File: rtl/pgx_group_exec.sv
module pgx_group_exec #(
  parameter int DW    = 16,
  parameter int NREG  = 8,
  parameter int NPRED = 8,
  localparam int RW   = $clog2(NREG),
  localparam int PW   = $clog2(NPRED)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_op,
  input  logic [PW-1:0] in_guard,
  input  logic [RW-1:0] in_dst,
  input  logic [PW-1:0] in_pt,
  input  logic [PW-1:0] in_pf,
  input  logic [RW-1:0] in_ra,
  input  logic [RW-1:0] in_rb,
  input  logic [DW-1:0] in_imm,
  input  logic          in_stop,
  output logic          err_o,
  input  logic [RW-1:0] obs_ridx,
  output logic [DW-1:0] obs_rdat,
  input  logic [PW-1:0] obs_pidx,
  output logic          obs_pdat
);
  import pgx_pkg::*;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic fire, commit, dup_d, dup_p;
  logic [2:0][RW-1:0]        drd_idx;
  logic [2:0][DW-1:0]        drd_dat;
  logic [1:0][PW-1:0]        prd_idx;
  logic [1:0][0:0]           prd_dat;
  logic [NREG-1:0][DW-1:0]   darch;
  logic [NPRED-1:0][0:0]     parch;
  logic [DW-1:0]             alu_res;
  logic                      a_gt_b, guard_ok, is_cmp;
  logic [0:0]                dwe;
  logic [1:0]                pwe;
  logic [1:0][PW-1:0]        pw_idx;
  logic [1:0][0:0]           pw_dat;

  assign drd_idx  = {obs_ridx, in_rb, in_ra};
  assign prd_idx  = {obs_pidx, in_guard};
  assign guard_ok = prd_dat[0][0];
  assign is_cmp   = (pgx_op_e'(in_op) == OP_CMPGT);
  assign dwe      = fire && guard_ok && !is_cmp;
  assign pwe      = {2{fire && guard_ok && is_cmp}};
  assign pw_idx   = {in_pf, in_pt};
  assign pw_dat   = {~a_gt_b, a_gt_b};
  assign obs_rdat = drd_dat[2];
  assign obs_pdat = prd_dat[1][0];

  pgx_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_s2),
    .in_valid (in_valid),
    .in_stop  (in_stop),
    .dup_any  (dup_d | dup_p),
    .in_ready (in_ready),
    .fire     (fire),
    .commit   (commit),
    .err_o    (err_o)
  );

  pgx_alu #(.DW(DW)) u_alu (
    .op     (in_op),
    .src_a  (drd_dat[0]),
    .src_b  (drd_dat[1]),
    .imm    (in_imm),
    .result (alu_res),
    .a_gt_b (a_gt_b)
  );

  pgx_regfile #(.NENT(NREG), .W(DW), .NWP(1), .NRP(3), .HARD0(1'b0)) u_dreg (
    .clk    (clk),
    .rst_n  (rst_s2),
    .wr_en  (dwe),
    .wr_idx (in_dst),
    .wr_dat (alu_res),
    .commit (commit),
    .rd_idx (drd_idx),
    .rd_dat (drd_dat),
    .arch_o (darch),
    .dup_o  (dup_d)
  );

  pgx_regfile #(.NENT(NPRED), .W(1), .NWP(2), .NRP(2), .HARD0(1'b1)) u_preg (
    .clk    (clk),
    .rst_n  (rst_s2),
    .wr_en  (pwe),
    .wr_idx (pw_idx),
    .wr_dat (pw_dat),
    .commit (commit),
    .rd_idx (prd_idx),
    .rd_dat (prd_dat),
    .arch_o (parch),
    .dup_o  (dup_p)
  );
endmodule

// File: rtl/pgx_chk.sv
module pgx_chk #(
  parameter int DW    = 16,
  parameter int NREG  = 8,
  parameter int NPRED = 8,
  localparam int PW   = $clog2(NPRED)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    in_stop,
  input logic                    err_o,
  input logic                    commit,
  input logic [PW-1:0]           obs_pidx,
  input logic                    obs_pdat,
  input logic [NREG-1:0][DW-1:0] darch,
  input logic [NPRED-1:0][0:0]   parch
);
  // R4
  stop_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_stop) |=> !in_ready);

  // R4
  stall_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  // R6
  err_in_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !in_ready);

  // R3
  dreg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(darch));

  // R3
  preg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(parch));

  // R5
  p0_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_pidx == '0) |-> obs_pdat);
endmodule

bind pgx_group_exec pgx_chk #(.DW(DW), .NREG(NREG), .NPRED(NPRED)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_stop  (in_stop),
  .err_o    (err_o),
  .commit   (commit),
  .obs_pidx (obs_pidx),
  .obs_pdat (obs_pdat),
  .darch    (darch),
  .parch    (parch)
);

// File: tb/sim_pgx_group_exec.sv
module sim_pgx_group_exec;
  localparam int DW = 16, NREG = 8, NPRED = 8, RW = 3, PW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_stop = 1'b0;
  logic in_ready, err_o, obs_pdat;
  logic [1:0] in_op = '0;
  logic [PW-1:0] in_guard = '0, in_pt = '0, in_pf = '0, obs_pidx = '0;
  logic [RW-1:0] in_dst = '0, in_ra = '0, in_rb = '0, obs_ridx = '0;
  logic [DW-1:0] in_imm = '0, obs_rdat;

  always #4 clk = ~clk;

  pgx_group_exec #(.DW(DW), .NREG(NREG), .NPRED(NPRED)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_guard(in_guard), .in_dst(in_dst), .in_pt(in_pt),
    .in_pf(in_pf), .in_ra(in_ra), .in_rb(in_rb), .in_imm(in_imm),
    .in_stop(in_stop), .err_o(err_o), .obs_ridx(obs_ridx), .obs_rdat(obs_rdat),
    .obs_pidx(obs_pidx), .obs_pdat(obs_pdat)
  );

  typedef struct {
    bit        is_pred;
    int        idx;
    logic [DW-1:0] exp;
    string     req;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Reference state: committed values plus the pending writes of the open group.
  logic [DW-1:0] mreg [NREG];
  bit            mpred[NPRED];
  bit            pv[NREG];
  logic [DW-1:0] pd[NREG];
  bit            ppv[NPRED];
  bit            ppd[NPRED];
  bit            mdup;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares them at the read ports.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        if (it.is_pred) obs_pidx = PW'(it.idx); else obs_ridx = RW'(it.idx);
        #1;
        if (it.is_pred) chk(obs_pdat == it.exp[0], it.req, obs_pdat, it.exp[0]);
        else            chk(obs_rdat == it.exp, it.req, obs_rdat, it.exp);
      end
    end
  end

  task automatic push_all(input string req);
    for (int i = 0; i < NREG; i++) begin
      item_t it;
      it.is_pred = 0; it.idx = i; it.exp = mreg[i]; it.req = req;
      q.push_back(it);
    end
    for (int i = 0; i < NPRED; i++) begin
      item_t it;
      it.is_pred = 1; it.idx = i; it.exp = DW'(mpred[i]); it.req = req;
      q.push_back(it);
    end
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic model_wr(input int d, input logic [DW-1:0] v);
    if (pv[d]) mdup = 1;
    pv[d] = 1; pd[d] = v;
  endtask

  task automatic model_pw(input int p, input bit v);
    if (p == 0) return;
    if (ppv[p]) mdup = 1;
    ppv[p] = 1; ppd[p] = v;
  endtask

  // Driver: issues one operation, updates the reference, handles the commit.
  task automatic issue(input int op, input int g, input int dst, input int pt,
                       input int pf, input int ra, input int rb,
                       input logic [DW-1:0] imm, input bit stop, input string req);
    logic [DW-1:0] a, b;
    a = mreg[ra]; b = mreg[rb];
    if (mpred[g]) begin
      case (op)
        0: model_wr(dst, imm);
        1: model_wr(dst, a);
        2: model_wr(dst, a + b);
        default: begin model_pw(pt, a > b); model_pw(pf, !(a > b)); end
      endcase
    end
    @(negedge clk);
    in_valid = 1; in_op = 2'(op); in_guard = PW'(g); in_dst = RW'(dst);
    in_pt = PW'(pt); in_pf = PW'(pf); in_ra = RW'(ra); in_rb = RW'(rb);
    in_imm = imm; in_stop = stop;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    if (stop) begin
      @(negedge clk);
      in_valid = 0; in_stop = 0;
      chk(in_ready == 1'b0, {req, " R4 ready low in commit"}, in_ready, 0);
      chk(err_o == mdup, {req, " R6 err_o"}, err_o, mdup);
      @(negedge clk);
      chk(in_ready == 1'b1, {req, " R4 ready back"}, in_ready, 1);
      for (int i = 0; i < NREG; i++) if (pv[i]) mreg[i] = pd[i];
      for (int i = 1; i < NPRED; i++) if (ppv[i]) mpred[i] = ppd[i];
      for (int i = 0; i < NREG; i++) pv[i] = 0;
      for (int i = 0; i < NPRED; i++) ppv[i] = 0;
      mdup = 0;
      push_all(req);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin mreg[i] = '0; pv[i] = 0; pd[i] = '0; end
    for (int i = 0; i < NPRED; i++) begin mpred[i] = (i == 0); ppv[i] = 0; ppd[i] = 0; end
    mdup = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R8: reset state
    chk(in_ready == 1'b1, "R8 ready after reset", in_ready, 1);
    chk(err_o == 1'b0, "R8 err after reset", err_o, 0);
    push_all("R8 reset values");

    // R7: loads, guarded by predicate 0 (R5)
    issue(0, 0, 1, 0, 0, 0, 0, 16'd5, 0, "R7 load");
    issue(0, 0, 2, 0, 0, 0, 0, 16'd9, 1, "R7 load");
    // R3: swap reads pre-group values
    issue(1, 0, 1, 0, 0, 2, 0, '0, 0, "R3 swap");
    issue(1, 0, 2, 0, 0, 1, 0, '0, 1, "R3 swap");
    // R1: 9 > 5 -> p1=1, p2=0
    issue(3, 0, 0, 1, 2, 1, 2, '0, 1, "R1 compare true");
    // R2: guarded pair selects one write; R7 add
    issue(0, 1, 3, 0, 0, 0, 0, 16'd100, 0, "R2 guarded pair");
    issue(0, 2, 3, 0, 0, 0, 0, 16'd200, 0, "R2 guarded pair");
    issue(2, 0, 4, 0, 0, 1, 2, '0, 1, "R7 add");
    // R3: compare flips p1 but the guard uses the old p1
    issue(3, 0, 0, 1, 2, 2, 1, '0, 0, "R3 stale guard");
    issue(0, 1, 5, 0, 0, 0, 0, 16'd7, 1, "R3 stale guard");
    // R2: p1 now false; neither write nor compare takes effect
    issue(0, 1, 5, 0, 0, 0, 0, 16'd99, 0, "R2 false guard");
    issue(3, 1, 0, 3, 4, 1, 2, '0, 1, "R2 false guard cmp");
    // R6: duplicate data destination, later write wins
    issue(0, 0, 6, 0, 0, 0, 0, 16'd1, 0, "R6 dup data");
    issue(0, 0, 6, 0, 0, 0, 0, 16'd2, 1, "R6 dup data");
    // R5: write to predicate 0 discarded
    issue(3, 0, 0, 0, 3, 2, 1, '0, 1, "R5 p0 write");
    // R7: add wraps modulo 2^DW
    issue(0, 0, 7, 0, 0, 0, 0, 16'hFFFF, 1, "R7 wrap load");
    issue(2, 0, 7, 0, 0, 7, 1, '0, 1, "R7 wrap add");
    // R6: duplicate predicate destinations, later compare wins
    issue(3, 0, 0, 5, 6, 1, 2, '0, 0, "R6 dup pred");
    issue(3, 0, 0, 5, 6, 2, 1, '0, 1, "R6 dup pred");
    // R1: equal operands give false
    issue(3, 0, 0, 3, 4, 1, 1, '0, 1, "R1 compare equal");
    // R6: one compare naming the same predicate twice, complement kept
    issue(3, 0, 0, 7, 7, 1, 2, '0, 1, "R6 same pt pf");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule